// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block sends ARINC 429 words from a host. The host writes each 31-bit word as two halves over a 16-bit bus. Each half has its own strobe, and the low half comes first. Committed words wait in an eight-entry FIFO.

While the transmit enable is high, the serializer takes words from the FIFO one at a time. It appends a generated parity bit and sends the 32 bits least significant first. The line is return-to-zero and uses two rails, `line_one` and `line_zero`. Each bit pulses one rail for the first half of its period, then both rails rest low for the second half. After each word comes a fixed null gap of four bit periods.

A configuration strobe latches the bit rate and the parity sense. Master reset does not touch these settings. The `tx_ready` flag tells the host when the FIFO and the serializer are both empty.

Top module: `a429_tx_top`

## Requirements
- R1: A word is committed when `ld_hi` arrives after an `ld_lo` that has not yet been used. `ld_lo` latches `host_data` as the low half. `ld_hi` uses `host_data[14:0]` as the high half. An `ld_hi` with no pending low half is ignored.
- R2: The FIFO holds 8 words. A commit attempted while it is full is ignored, and that word is never transmitted.
- R3: `tx_ready` goes low in the cycle after a commit. It returns high only when the FIFO is empty and the serializer has finished the last word's gap.
- R4: Each bit lasts DIV clocks. During the first DIV/2 clocks, `line_one` is high for a 1 and `line_zero` is high for a 0. The rest of the bit is null (both low). The two rails are never high together.
- R5: DIV is 10 when the latched rate bit `cfg_slow` is 0, and 80 when it is 1. `cfg_slow` is latched on `cfg_wr`.
- R6: The transmit order is low half bit 0 first, through low half bit 15, then high half bits 0 to 14, then the parity bit. `host_data[15]` during `ld_hi` has no effect.
- R7: The parity bit makes the count of ones across all 32 bits odd when the latched `cfg_even` is 0, and even when it is 1.
- R8: After the parity bit's period, the rails stay null for exactly 4×DIV clocks. If the enable is high and a word is waiting, the next word's first bit starts on the following clock.
- R9: When the serializer is idle and a word is waiting, the first bit appears one clock after `tx_en` is sampled high.
- R10: If `tx_en` is sampled low while data bits are going out, the word is abandoned. The rails are null from the next cycle, and the word is not resent.
- R11: Synchronous active-low `rst_n` stops transmission, empties the FIFO, drops any pending low half and raises `tx_ready`. The latched rate and parity settings are kept.
- R12: While idle or disabled, both rails stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| cfg_wr | input | 1 | Latch `cfg_slow` and `cfg_even` |
| cfg_slow | input | 1 | Rate select: 0 = divide by 10, 1 = divide by 80 |
| cfg_even | input | 1 | Parity sense: 0 = odd, 1 = even |
| host_data | input | 16 | Host data bus for both halves |
| ld_lo | input | 1 | Low-half load strobe |
| ld_hi | input | 1 | High-half load strobe; commits the word |
| tx_en | input | 1 | Transmit enable |
| line_one | output | 1 | Return-to-zero rail for 1 bits |
| line_zero | output | 1 | Return-to-zero rail for 0 bits |
| tx_ready | output | 1 | High when nothing is queued or in flight |

## Verification
A host commit and a serializer pop can land on the same clock edge. The edge that ends one word's gap pops the next queued word, and it may also commit a new word. The bench provokes this by placing `ld_hi` in exactly the last gap cycle, while another word is already queued. It then checks that both the popped word and the newly pushed word go out intact and in order, followed by a correct return of `tx_ready`.

// File: rtl/a429_pkg.sv
// Package: shared word type, serializer state encoding and parity helper
// for the ARINC 429 word transmitter. Assumes a fixed 31-bit payload.
package a429_pkg;

    localparam int unsigned PAYLOAD_W = 31;
    localparam int unsigned FRAME_W   = PAYLOAD_W + 1;
    localparam int unsigned HALF_W    = 16;

    typedef logic [PAYLOAD_W-1:0] payload_t;
    typedef logic [FRAME_W-1:0]   frame_t;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_BITS = 2'd1,
        SER_GAP  = 2'd2
    } ser_state_e;

    // Parity bit that gives an odd total (even_sel=0) or even total (1).
    function automatic logic frame_parity(input payload_t d, input logic even_sel);
        return (~(^d)) ^ even_sel;
    endfunction

endpackage

// File: rtl/a429_half_loader.sv
// Module: joins the two host halves into one payload word.
// The low half is held until a high-half strobe uses it. A high-half strobe
// with no pending low half is dropped. Assumes the strobes are one-cycle
// pulses synchronous to clk.
module a429_half_loader
    import a429_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] host_data,
    input  logic              ld_lo,
    input  logic              ld_hi,
    output logic              commit,
    output payload_t          commit_word,
    output logic              lo_pending
);

    logic [HALF_W-1:0] lo_q;
    logic              pend_q;
    logic              unused_msb;

    // Capture the low half and track whether one is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            pend_q <= 1'b0;
        end else if (ld_lo) begin
            lo_q   <= host_data;
            pend_q <= 1'b1;
        end else if (ld_hi) begin
            pend_q <= 1'b0;
        end
    end

    // Commit only when a high half meets a pending low half.
    always_comb begin
        commit      = ld_hi && pend_q;
        commit_word = {host_data[PAYLOAD_W-HALF_W-1:0], lo_q};
    end

    assign unused_msb = host_data[HALF_W-1];
    assign lo_pending = pend_q;

endmodule

// File: rtl/a429_word_fifo.sv
// Module: payload FIFO of DEPTH words.
// Pushes into a full FIFO and pops from an empty one are dropped. Push and
// pop may occur in the same cycle. Storage is not reset; the pointers are.
module a429_word_fifo
    import a429_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  payload_t                   push_word,
    input  logic                       pop,
    output payload_t                   head_word,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int unsigned AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNW = $clog2(DEPTH+1);
    localparam logic [AW-1:0]  LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CNW-1:0] FULL_CNT = CNW'(DEPTH);

    payload_t       mem [DEPTH];
    logic [AW-1:0]  wr_q, rd_q;
    logic [CNW-1:0] cnt_q;
    logic           push_ok, pop_ok;

    // Qualify requests against the occupancy seen at this edge.
    always_comb begin
        push_ok = push && (cnt_q != FULL_CNT);
        pop_ok  = pop && (cnt_q != '0);
    end

    // Write the storage array.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_q] <= push_word;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) begin
                wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_word = mem[rd_q];
    assign empty     = (cnt_q == '0);
    assign count     = cnt_q;

endmodule

// File: rtl/a429_serializer.sv
// Module: return-to-zero serializer with parity and word gap.
// Sends 32 bits LSB first, each DIV clocks long with the pulse in the first
// half, then holds null for GAP_BITS*DIV clocks. Dropping tx_en during the
// data bits abandons the word; the gap always runs to completion.
// Assumes the rate bit is not changed while a word is in flight.
module a429_serializer
    import a429_pkg::*;
#(
    parameter int unsigned HS_DIV   = 10,
    parameter int unsigned LS_DIV   = 80,
    parameter int unsigned GAP_BITS = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tx_en,
    input  logic     slow,
    input  logic     even_sel,
    input  logic     fifo_empty,
    input  payload_t fifo_word,
    output logic     pop,
    output logic     line_one,
    output logic     line_zero,
    output logic     busy,
    output logic     in_word
);

    localparam int unsigned MAX_DIV = (LS_DIV > HS_DIV) ? LS_DIV : HS_DIV;
    localparam int unsigned CW      = $clog2(MAX_DIV);
    localparam int unsigned MAX_IDX = (FRAME_W > GAP_BITS) ? FRAME_W : GAP_BITS;
    localparam int unsigned IW      = $clog2(MAX_IDX);
    localparam logic [CW-1:0] HS_LAST = CW'(HS_DIV - 1);
    localparam logic [CW-1:0] LS_LAST = CW'(LS_DIV - 1);
    localparam logic [CW-1:0] HS_HALF = CW'(HS_DIV / 2);
    localparam logic [CW-1:0] LS_HALF = CW'(LS_DIV / 2);
    localparam logic [IW-1:0] LAST_BIT = IW'(FRAME_W - 1);
    localparam logic [IW-1:0] LAST_GAP = IW'(GAP_BITS - 1);

    ser_state_e    state_q;
    logic [CW-1:0] cyc_q;
    logic [IW-1:0] idx_q;
    frame_t        sh_q;
    logic [CW-1:0] cyc_last, cyc_half;
    logic          start_ok, cell_end, gap_end;
    frame_t        next_frame;

    // Select rate-dependent limits and decode the period boundaries.
    always_comb begin
        cyc_last   = slow ? LS_LAST : HS_LAST;
        cyc_half   = slow ? LS_HALF : HS_HALF;
        start_ok   = tx_en && !fifo_empty;
        cell_end   = (cyc_q == cyc_last);
        gap_end    = (state_q == SER_GAP) && cell_end && (idx_q == LAST_GAP);
        next_frame = {frame_parity(fifo_word, even_sel), fifo_word};
        pop        = start_ok && ((state_q == SER_IDLE) || gap_end);
    end

    // Sequence the data bits, the gap and word hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            cyc_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            case (state_q)
                SER_IDLE: begin
                    if (start_ok) begin
                        state_q <= SER_BITS;
                        sh_q    <= next_frame;
                        cyc_q   <= '0;
                        idx_q   <= '0;
                    end
                end
                SER_BITS: begin
                    if (!tx_en) begin
                        state_q <= SER_IDLE;
                        cyc_q   <= '0;
                        idx_q   <= '0;
                    end else if (cell_end) begin
                        cyc_q <= '0;
                        sh_q  <= sh_q >> 1;
                        if (idx_q == LAST_BIT) begin
                            state_q <= SER_GAP;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                SER_GAP: begin
                    if (cell_end) begin
                        cyc_q <= '0;
                        if (idx_q == LAST_GAP) begin
                            idx_q <= '0;
                            if (start_ok) begin
                                state_q <= SER_BITS;
                                sh_q    <= next_frame;
                            end else begin
                                state_q <= SER_IDLE;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= SER_IDLE;
                end
            endcase
        end
    end

    // Drive the rails from the current bit during the pulse half only.
    always_comb begin
        in_word   = (state_q == SER_BITS);
        busy      = (state_q != SER_IDLE);
        line_one  = in_word && (cyc_q < cyc_half) && sh_q[0];
        line_zero = in_word && (cyc_q < cyc_half) && !sh_q[0];
    end

endmodule

// File: rtl/a429_tx_top.sv
// Module: ARINC 429 word transmitter top.
// Holds the rate and parity settings, which master reset leaves alone.
// Wires the half loader into the FIFO and the FIFO into the serializer.
// Ready is high when nothing is queued and nothing is in flight.
module a429_tx_top
    import a429_pkg::*;
#(
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned HS_DIV   = 10,
    parameter int unsigned LS_DIV   = 80,
    parameter int unsigned GAP_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_slow,
    input  logic        cfg_even,
    input  logic [15:0] host_data,
    input  logic        ld_lo,
    input  logic        ld_hi,
    input  logic        tx_en,
    output logic        line_one,
    output logic        line_zero,
    output logic        tx_ready
);

    localparam int unsigned CNW = $clog2(DEPTH+1);

    logic           slow_q, even_q;
    logic           fifo_push, fifo_pop, fifo_empty;
    payload_t       push_word, head_word;
    logic [CNW-1:0] fifo_count;
    logic           ld_pending, ser_busy, ser_in_word;

    // Settings register: deliberately outside master reset.
    always_ff @(posedge clk) begin
        if (cfg_wr) begin
            slow_q <= cfg_slow;
            even_q <= cfg_even;
        end
    end

    a429_half_loader loader_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_data   (host_data),
        .ld_lo       (ld_lo),
        .ld_hi       (ld_hi),
        .commit      (fifo_push),
        .commit_word (push_word),
        .lo_pending  (ld_pending)
    );

    a429_word_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_word (push_word),
        .pop       (fifo_pop),
        .head_word (head_word),
        .empty     (fifo_empty),
        .count     (fifo_count)
    );

    a429_serializer #(
        .HS_DIV   (HS_DIV),
        .LS_DIV   (LS_DIV),
        .GAP_BITS (GAP_BITS)
    ) ser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .slow       (slow_q),
        .even_sel   (even_q),
        .fifo_empty (fifo_empty),
        .fifo_word  (head_word),
        .pop        (fifo_pop),
        .line_one   (line_one),
        .line_zero  (line_zero),
        .busy       (ser_busy),
        .in_word    (ser_in_word)
    );

    // Ready reflects an empty queue and an idle serializer.
    always_comb begin
        tx_ready = fifo_empty && !ser_busy;
    end

endmodule

// File: rtl/a429_tx_chk.sv
// Checker: temporal properties of the transmitter, bound to the top module.
module a429_tx_chk #(
    parameter int unsigned DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tx_en,
    input logic                       ld_hi,
    input logic                       line_one,
    input logic                       line_zero,
    input logic                       tx_ready,
    input logic                       ld_pending,
    input logic                       fifo_push,
    input logic                       fifo_pop,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count,
    input logic                       ser_in_word
);

    assert_rails_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_one && line_zero));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

    assert_orphan_high_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !ld_pending && !fifo_pop) |=> (fifo_count == $past(fifo_count)));

    assert_ready_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> !tx_ready);

    assert_ready_means_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!line_one && !line_zero));

    assert_abort_nulls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_in_word && !tx_en) |=> (!line_one && !line_zero));

    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> (tx_ready && !line_one && !line_zero && fifo_count == '0));

endmodule

bind a429_tx_top a429_tx_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .ld_hi       (ld_hi),
    .line_one    (line_one),
    .line_zero   (line_zero),
    .tx_ready    (tx_ready),
    .ld_pending  (ld_pending),
    .fifo_push   (fifo_push),
    .fifo_pop    (fifo_pop),
    .fifo_count  (fifo_count),
    .ser_in_word (ser_in_word)
);

// File: tb/a429_tx_top_tb_top.sv
`timescale 1ns/1ps
module a429_tx_top_tb_top;

    localparam int HS = 10;
    localparam int LS = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_slow = 1'b0, cfg_even = 1'b0;
    logic [15:0] host_data = '0;
    logic        ld_lo = 1'b0, ld_hi = 1'b0, tx_en = 1'b0;
    logic        line_one, line_zero, tx_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    a429_tx_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_slow(cfg_slow),
        .cfg_even(cfg_even), .host_data(host_data), .ld_lo(ld_lo),
        .ld_hi(ld_hi), .tx_en(tx_en), .line_one(line_one),
        .line_zero(line_zero), .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected value of frame bit i (bit 31 is parity).
    function automatic bit exp_bit(input logic [30:0] w, input bit even, input int i);
        bit par;
        par = ($countones(w) % 2 == 1) ? even : !even;
        return (i < 31) ? w[i] : par;
    endfunction

    function automatic logic [30:0] rnd_word();
        return 31'($urandom);
    endfunction

    task automatic set_cfg(input bit slow, input bit even);
        @(negedge clk);
        cfg_slow = slow; cfg_even = even; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Two-strobe load; bit 15 of the high half is random junk (R6).
    task automatic load_word(input logic [30:0] w);
        @(negedge clk);
        host_data = w[15:0]; ld_lo = 1'b1;
        @(negedge clk);
        ld_lo = 1'b0; ld_hi = 1'b1;
        host_data = {1'($urandom), w[30:16]};
        @(negedge clk);
        ld_hi = 1'b0;
    endtask

    // Called at the negedge showing cycle 0 of the frame; returns at the
    // negedge showing the first gap cycle.
    task automatic check_frame(input logic [30:0] w, input bit even, input int div,
                               input string req);
        for (int b = 0; b < 32; b++) begin
            int bad = 0;
            logic [1:0] a_first = 2'b00, e_first = 2'b00;
            bit v = exp_bit(w, even, b);
            for (int c = 0; c < div; c++) begin
                logic [1:0] e;
                e = (c < div/2) ? {v, !v} : 2'b00;
                if ({line_one, line_zero} !== e) begin
                    if (bad == 0) begin a_first = {line_one, line_zero}; e_first = e; end
                    bad++;
                end
                @(negedge clk);
            end
            chk(bad == 0, req, $sformatf("frame bit %0d", b + 1), a_first, e_first);
        end
    endtask

    // Checks the null gap (R8); optional commit lands on the last gap cycle.
    task automatic check_gap(input int div, input bit push_end, input logic [30:0] pw);
        int bad = 0;
        for (int g = 0; g < 4*div; g++) begin
            if (line_one || line_zero || tx_ready) bad++;
            if (push_end && g == 0) begin host_data = pw[15:0]; ld_lo = 1'b1; end
            if (push_end && g == 1) ld_lo = 1'b0;
            if (push_end && g == 4*div-1) begin
                host_data = {1'b0, pw[30:16]}; ld_hi = 1'b1;
            end
            @(negedge clk);
            ld_hi = 1'b0;
        end
        chk(bad == 0, "R8", "gap null cycles with bad rails", bad, 0);
    endtask

    task automatic check_quiet(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (line_one || line_zero) bad++;
            @(negedge clk);
        end
        chk(bad == 0, req, "rails active while idle", bad, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [30:0] wa, wb, wc;
        logic [30:0] ws [9];
        void'($urandom(32'd1429));
        set_cfg(1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready === 1'b1, "R11", "ready after reset", tx_ready, 1);
        chk({line_one, line_zero} === 2'b00, "R12", "rails after reset", {line_one, line_zero}, 0);

        // R3/R12: single load while disabled.
        wa = rnd_word();
        load_word(wa);
        chk(tx_ready === 1'b0, "R3", "ready after commit", tx_ready, 0);
        check_quiet(15, "R12");
        // R9/R4/R5/R6/R7: fast, odd parity.
        tx_en = 1'b1;
        @(negedge clk);
        check_frame(wa, 1'b0, HS, "R9");
        check_gap(HS, 1'b0, '0);
        chk(tx_ready === 1'b1, "R3", "ready after last gap", tx_ready, 1);
        check_quiet(10, "R12");

        // R8/R7: three back-to-back words, even parity.
        tx_en = 1'b0;
        set_cfg(1'b0, 1'b1);
        ws[0] = 31'h0; ws[1] = 31'h7fffffff; ws[2] = rnd_word();
        for (int i = 0; i < 3; i++) load_word(ws[i]);
        tx_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check_frame(ws[i], 1'b1, HS, "R7");
            check_gap(HS, 1'b0, '0);
        end
        chk(tx_ready === 1'b1, "R3", "ready after burst", tx_ready, 1);

        // R1: orphan high half ignored.
        @(negedge clk);
        host_data = 16'h1234; ld_hi = 1'b1;
        @(negedge clk);
        ld_hi = 1'b0;
        @(negedge clk);
        chk(tx_ready === 1'b1, "R1", "ready after orphan high strobe", tx_ready, 1);
        check_quiet(20, "R1");

        // R2: nine loads, only eight go out.
        tx_en = 1'b0;
        set_cfg(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) begin ws[i] = rnd_word(); load_word(ws[i]); end
        tx_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            check_frame(ws[i], 1'b0, HS, "R2");
            check_gap(HS, 1'b0, '0);
        end
        chk(tx_ready === 1'b1, "R2", "ready after eight words", tx_ready, 1);
        check_quiet(20, "R2");

        // R5: slow rate, two words.
        tx_en = 1'b0;
        set_cfg(1'b1, 1'b0);
        wa = rnd_word(); wb = rnd_word();
        load_word(wa); load_word(wb);
        tx_en = 1'b1;
        @(negedge clk);
        check_frame(wa, 1'b0, LS, "R5");
        check_gap(LS, 1'b0, '0);
        check_frame(wb, 1'b0, LS, "R5");
        check_gap(LS, 1'b0, '0);
        chk(tx_ready === 1'b1, "R5", "ready after slow words", tx_ready, 1);

        // R10: abort mid-word; the word is lost, the next one follows.
        tx_en = 1'b0;
        set_cfg(1'b0, 1'b0);
        wa = rnd_word(); wb = rnd_word();
        load_word(wa); load_word(wb);
        tx_en = 1'b1;
        repeat (3*HS + 3) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk({line_one, line_zero} === 2'b00, "R10", "rails after abort", {line_one, line_zero}, 0);
        chk(tx_ready === 1'b0, "R10", "ready with word left", tx_ready, 0);
        check_quiet(12, "R10");
        tx_en = 1'b1;
        @(negedge clk);
        check_frame(wb, 1'b0, HS, "R10");
        check_gap(HS, 1'b0, '0);
        chk(tx_ready === 1'b1, "R10", "ready after resend-free drain", tx_ready, 1);

        // Same-edge push and pop at gap end.
        tx_en = 1'b0;
        wa = rnd_word(); wb = rnd_word(); wc = rnd_word();
        load_word(wa); load_word(wb);
        tx_en = 1'b1;
        @(negedge clk);
        check_frame(wa, 1'b0, HS, "R8");
        check_gap(HS, 1'b1, wc);
        check_frame(wb, 1'b0, HS, "R8");
        check_gap(HS, 1'b0, '0);
        check_frame(wc, 1'b0, HS, "R1");
        check_gap(HS, 1'b0, '0);
        chk(tx_ready === 1'b1, "R3", "ready after push/pop overlap", tx_ready, 1);

        // R11: reset mid-word keeps slow/even settings.
        tx_en = 1'b0;
        set_cfg(1'b1, 1'b1);
        wa = rnd_word(); wb = rnd_word();
        load_word(wa); load_word(wb);
        @(negedge clk);
        host_data = 16'hbeef; ld_lo = 1'b1;
        @(negedge clk);
        ld_lo = 1'b0;
        tx_en = 1'b1;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(tx_ready === 1'b1, "R11", "ready in reset", tx_ready, 1);
        chk({line_one, line_zero} === 2'b00, "R11", "rails in reset", {line_one, line_zero}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        host_data = 16'h0; ld_hi = 1'b1;
        @(negedge clk);
        ld_hi = 1'b0;
        @(negedge clk);
        chk(tx_ready === 1'b1, "R11", "pending half dropped by reset", tx_ready, 1);
        check_quiet(10, "R11");
        wc = rnd_word();
        load_word(wc);
        @(negedge clk);
        check_frame(wc, 1'b1, LS, "R11");
        check_gap(LS, 1'b0, '0);
        chk(tx_ready === 1'b1, "R11", "ready after post-reset word", tx_ready, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule